// File: doc/BRIEF.md
# Boundary-Scan Interconnect Test Sequencer

This block is a scan-chain master for board interconnect testing. It generates the test clock, mode-select and data-in pins, and samples the data-out pin. It also keeps an internal copy of the 16-state test-access-port controller, which follows the target's controller edge by edge. One start pulse runs the whole test without further help. The block resets the target port, loads the sample/preload instruction and preloads the first stimulus. It then loads the external-test instruction, and at that instruction's update the preloaded stimulus drives the board nets. After that it runs one capture-and-shift pass per pattern. Each pass shifts out the captured response while the next stimulus shifts in. After the last pattern a safe vector is shifted in, and the port is returned to its reset state.

Each shifted-out response is compared with an expected vector under a mask. Every instruction capture is checked for the fixed low-order bits. Any mismatch latches a fail flag. The instruction codes, the instruction-register length, the chain length, the pattern count and the stimulus, expected, mask and safe vectors are inputs that stay static during a run. The test clock is a divided system clock.

Top module: `jtag_extest_seq`

## Requirements
- R1: Out of reset and while idle, `busy`, `done`, `fail` and `tck` are low and `tms` is high.
- R2: After `start`, the first five rising `tck` edges all see `tms` high, so the target's controller reaches its reset state from any state before the first low `tms`.
- R3: `tms` and `tdi` change only together with a falling `tck` edge, never at a rising one. `tdo` is sampled at rising edges.
- R4: A run takes exactly 5 + 1 + 2·(ir_len + 6) + (pat_cnt + 1)·(chain_len + 5) + 5 rising `tck` edges. This is reset, idle entry, two instruction loads, the preload, one pass per pattern and the final reset.
- R5: The target receives exactly two instruction updates, `sample_code` first and then `extest_code`.
- R6: Pattern k (0-based) is preloaded or shifted in before capture k. The response captured after pattern k is compared with `exp_vec[k]`. A board whose captures match reports `done` with `fail` low.
- R7: All shifts are LSB first. `tms` is high on the last bit of every shift only, so each shift leaves through Exit1 into Update.
- R8: A response bit counts as a mismatch only where its `mask_vec` bit is 1 and its index is below `chain_len`. Any counted mismatch sets `fail`.
- R9: During each instruction shift the first two bits read from `tdo` must be 1 and then 0. Any other value sets `fail`, whatever the mask.
- R10: The last data shift loads `safe_vec` into the target's update stage. The run ends with the target in its reset state.
- R11: `busy` is high from the cycle after `start` until the run ends. Then `done` rises, `done` and `fail` hold until the next `start`, and `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to launch a run while idle |
| ir_len | input | $clog2(IR_W+1) | Instruction-register length, 2..IR_W |
| chain_len | input | $clog2(CHAIN_W+1) | Boundary chain length, 1..CHAIN_W |
| pat_cnt | input | $clog2(NPAT+1) | Number of patterns, 1..NPAT |
| sample_code | input | IR_W | Sample/preload instruction code |
| extest_code | input | IR_W | External-test instruction code |
| stim_vec | input | NPAT x CHAIN_W | Stimulus vectors |
| exp_vec | input | NPAT x CHAIN_W | Expected responses |
| mask_vec | input | NPAT x CHAIN_W | Compare masks, 1 = compared |
| safe_vec | input | CHAIN_W | Vector left in the chain at the end |
| tdo | input | 1 | Scan data from the chain |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Scan data to the chain |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, sticky |
| fail | output | 1 | Mismatch or bad instruction capture seen, sticky |

## Verification
The checker follows pin timing and the internal controller copy on every cycle. It checks that mode-select and data-in stay put across each rising test-clock edge, that the reset phase really ends in the controller's reset state, that every sampled shift bit falls in a shift state, that the run ends in reset, and that `done`, `fail` and `busy` stay consistent. Only the bench's scenarios can show the end-to-end results. These are the instruction order seen by a modelled target, LSB-first data and the stimulus-to-response pairing, the masking including bits beyond the chain length, detection of stuck nets and corrupted instruction captures, the exact edge count and the safe vector left behind.

// File: rtl/jtag_seq_pkg.sv
`timescale 1ns/1ps
package jtag_seq_pkg;

    typedef enum logic [3:0] {
        TAP_RESET, TAP_IDLE,
        TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR, TAP_PAU_DR, TAP_EX2_DR, TAP_UPD_DR,
        TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR, TAP_PAU_IR, TAP_EX2_IR, TAP_UPD_IR
    } tap_st_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_RST, PH_RTI, PH_HDR, PH_SHIFT, PH_TAIL, PH_FIN
    } phase_e;

    function automatic tap_st_e tap_next(input tap_st_e s, input logic m);
        case (s)
            TAP_RESET:  return m ? TAP_RESET  : TAP_IDLE;
            TAP_IDLE:   return m ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_DR: return m ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR: return m ? TAP_EX1_DR : TAP_SH_DR;
            TAP_SH_DR:  return m ? TAP_EX1_DR : TAP_SH_DR;
            TAP_EX1_DR: return m ? TAP_UPD_DR : TAP_PAU_DR;
            TAP_PAU_DR: return m ? TAP_EX2_DR : TAP_PAU_DR;
            TAP_EX2_DR: return m ? TAP_UPD_DR : TAP_SH_DR;
            TAP_UPD_DR: return m ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_IR: return m ? TAP_RESET  : TAP_CAP_IR;
            TAP_CAP_IR: return m ? TAP_EX1_IR : TAP_SH_IR;
            TAP_SH_IR:  return m ? TAP_EX1_IR : TAP_SH_IR;
            TAP_EX1_IR: return m ? TAP_UPD_IR : TAP_PAU_IR;
            TAP_PAU_IR: return m ? TAP_EX2_IR : TAP_PAU_IR;
            TAP_EX2_IR: return m ? TAP_UPD_IR : TAP_SH_IR;
            default:    return m ? TAP_SEL_DR : TAP_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/jtag_tck_div.sv
`timescale 1ns/1ps
module jtag_tck_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tck,
    output logic rise,
    output logic fall
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          tck;
    } div_t;

    div_t d, q;
    logic wrap;

    always_comb begin
        d    = q;
        wrap = run && (q.cnt == LAST);
        if (!run) begin
            d.cnt = '0;
            d.tck = 1'b0;
        end else if (wrap) begin
            d.cnt = '0;
            d.tck = ~q.tck;
        end else begin
            d.cnt = q.cnt + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tck  = q.tck;
    assign rise = wrap && !q.tck;
    assign fall = wrap &&  q.tck;
endmodule

// File: rtl/jtag_tap_model.sv
`timescale 1ns/1ps
module jtag_tap_model
    import jtag_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    adv,
    input  logic    tms,
    output tap_st_e state
);
    tap_st_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) st_d = tap_next(st_q, tms);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TAP_RESET;
        else        st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/jtag_extest_seq.sv
`timescale 1ns/1ps
module jtag_extest_seq
    import jtag_seq_pkg::*;
#(
    parameter int CHAIN_W = 8,
    parameter int IR_W    = 4,
    parameter int NPAT    = 4,
    parameter int DIV     = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [$clog2(IR_W+1)-1:0]      ir_len,
    input  logic [$clog2(CHAIN_W+1)-1:0]   chain_len,
    input  logic [$clog2(NPAT+1)-1:0]      pat_cnt,
    input  logic [IR_W-1:0]                sample_code,
    input  logic [IR_W-1:0]                extest_code,
    input  logic [NPAT-1:0][CHAIN_W-1:0]   stim_vec,
    input  logic [NPAT-1:0][CHAIN_W-1:0]   exp_vec,
    input  logic [NPAT-1:0][CHAIN_W-1:0]   mask_vec,
    input  logic [CHAIN_W-1:0]             safe_vec,
    input  logic                           tdo,
    output logic                           tck,
    output logic                           tms,
    output logic                           tdi,
    output logic                           busy,
    output logic                           done,
    output logic                           fail
);
    localparam int VW   = (CHAIN_W > IR_W) ? CHAIN_W : IR_W;
    localparam int CW0  = $clog2(VW + 1);
    localparam int CW   = (CW0 > 3) ? CW0 : 3;
    localparam int SW   = $clog2(NPAT + 4);
    localparam int RSTN = 5;

    typedef struct packed {
        phase_e          ph;
        logic [CW-1:0]   cnt;
        logic [SW-1:0]   step;
        logic            fin;
        logic [VW-1:0]   rsp;
        logic            done;
        logic            fail;
        logic            tms;
        logic            tdi;
    } seq_t;

    seq_t    d, q;
    logic    rise, fall;
    tap_st_e tap_state;
    phase_e  ph_cur;

    // program decode
    logic            is_ir, is_cmp;
    logic [SW-1:0]   kidx, nidx, last_step;
    logic [CW-1:0]   len, hdr_last;
    logic [VW-1:0]   vec, vec_sh, lenmask, rsp_nx, exp_k, mask_k;
    logic            pend_tms, pend_tdi, mism;

    assign busy   = (q.ph != PH_IDLE);
    assign ph_cur = q.ph;

    jtag_tck_div #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tck  (tck),
        .rise (rise),
        .fall (fall)
    );

    jtag_tap_model u_tap (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (rise),
        .tms  (q.tms),
        .state(tap_state)
    );

    always_comb begin
        is_ir     = (q.step == SW'(0)) || (q.step == SW'(2));
        is_cmp    = (q.step >= SW'(3));
        kidx      = q.step - SW'(3);
        nidx      = kidx + SW'(1);
        last_step = SW'(pat_cnt) + SW'(2);
        len       = is_ir ? CW'(ir_len) : CW'(chain_len);
        hdr_last  = is_ir ? CW'(3) : CW'(2);

        vec    = '0;
        exp_k  = '0;
        mask_k = '0;
        if (q.step == SW'(0)) begin
            vec = VW'(sample_code);
        end else if (q.step == SW'(2)) begin
            vec = VW'(extest_code);
        end else if (q.step == SW'(1)) begin
            vec = VW'(stim_vec[0]);
        end else if (nidx < SW'(pat_cnt)) begin
            for (int i = 0; i < NPAT; i++)
                if (nidx == SW'(i)) vec = VW'(stim_vec[i]);
        end else begin
            vec = VW'(safe_vec);
        end
        for (int i = 0; i < NPAT; i++) begin
            if (kidx == SW'(i)) begin
                exp_k  = VW'(exp_vec[i]);
                mask_k = VW'(mask_vec[i]);
            end
        end
        for (int i = 0; i < VW; i++) lenmask[i] = (CW'(i) < len);

        vec_sh = vec >> q.cnt;
        rsp_nx = q.rsp;
        for (int i = 0; i < VW; i++)
            if (q.cnt == CW'(i)) rsp_nx[i] = tdo;
        mism = |((rsp_nx ^ exp_k) & mask_k & lenmask);

        pend_tdi = 1'b0;
        case (q.ph)
            PH_RTI:   pend_tms = 1'b0;
            PH_HDR:   pend_tms = is_ir ? (q.cnt < CW'(2)) : (q.cnt == CW'(0));
            PH_SHIFT: begin
                pend_tms = (q.cnt == len - CW'(1));
                pend_tdi = vec_sh[0];
            end
            PH_TAIL:  pend_tms = (q.cnt == CW'(0));
            default:  pend_tms = 1'b1;
        endcase

        d = q;
        if (fall) begin
            d.tms = pend_tms;
            d.tdi = pend_tdi;
            if (q.ph == PH_FIN) begin
                d.ph   = PH_IDLE;
                d.done = 1'b1;
            end
        end
        if (rise) begin
            case (q.ph)
                PH_RST: begin
                    if (q.cnt == CW'(RSTN - 1)) begin
                        d.cnt = '0;
                        d.ph  = q.fin ? PH_FIN : PH_RTI;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                PH_RTI: begin
                    d.ph  = PH_HDR;
                    d.cnt = '0;
                end
                PH_HDR: begin
                    if (q.cnt == hdr_last) begin
                        d.ph  = PH_SHIFT;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                PH_SHIFT: begin
                    d.rsp = rsp_nx;
                    if (is_ir && (q.cnt == CW'(0)) && !tdo) d.fail = 1'b1;
                    if (is_ir && (q.cnt == CW'(1)) &&  tdo) d.fail = 1'b1;
                    if (q.cnt == len - CW'(1)) begin
                        if (is_cmp && mism) d.fail = 1'b1;
                        d.ph  = PH_TAIL;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                PH_TAIL: begin
                    if (q.cnt == CW'(1)) begin
                        d.cnt = '0;
                        if (q.step == last_step) begin
                            d.ph  = PH_RST;
                            d.fin = 1'b1;
                        end else begin
                            d.step = q.step + SW'(1);
                            d.ph   = PH_HDR;
                        end
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                default: ;
            endcase
        end
        if ((q.ph == PH_IDLE) && start) begin
            d.ph   = PH_RST;
            d.cnt  = '0;
            d.step = '0;
            d.fin  = 1'b0;
            d.done = 1'b0;
            d.fail = 1'b0;
            d.tms  = 1'b1;
            d.tdi  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.ph  <= PH_IDLE;
            q.tms <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tms  = q.tms;
    assign tdi  = q.tdi;
    assign done = q.done;
    assign fail = q.fail;
endmodule

// File: rtl/jtag_extest_chk.sv
`timescale 1ns/1ps
module jtag_extest_chk
    import jtag_seq_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    busy,
    input logic    done,
    input logic    fail,
    input logic    tck,
    input logic    tms,
    input logic    tdi,
    input logic    rise,
    input logic    fall,
    input phase_e  ph_cur,
    input tap_st_e tap_state
);
    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tck && tms)) else $error("idle pins");                       // R1
    AST_RESET_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && ph_cur == PH_RTI) |-> (tap_state == TAP_RESET)) else $error("reset");  // R2
    AST_PINS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck) |-> ($stable(tms) && $stable(tdi))) else $error("pin timing"); // R3
    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall)) else $error("edges");                                   // R3
    AST_SHIFT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && ph_cur == PH_SHIFT) |-> (tap_state == TAP_SH_DR || tap_state == TAP_SH_IR))
        else $error("shift state");                                              // R7
    AST_END_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (tap_state == TAP_RESET)) else $error("end state");      // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("done busy");                                // R11
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fail) |=> fail) else $error("fail hold");                       // R11
endmodule

bind jtag_extest_seq jtag_extest_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .tck      (tck),
    .tms      (tms),
    .tdi      (tdi),
    .rise     (rise),
    .fall     (fall),
    .ph_cur   (ph_cur),
    .tap_state(tap_state)
);

// File: tb/jtag_extest_seq_test.sv
`timescale 1ns/1ps
module jtag_extest_seq_test;
    localparam logic [3:0] SAMPLE = 4'h1;
    localparam logic [3:0] EXTEST = 4'h0;
    localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4, S_E1D = 5,
                   S_PDR = 6, S_E2D = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_SHIR = 11,
                   S_E1I = 12, S_PIR = 13, S_E2I = 14, S_UIR = 15;

    logic clk = 0, rst_n = 0, start = 0;
    logic [2:0] ir_len = 3'd4;
    logic [3:0] chain_len = 4'd4;
    logic [2:0] pat_cnt = 3'd1;
    logic [3:0][7:0] stim_v = '0, exp_v = '0, mask_v = '0;
    logic [7:0] safe_v = 8'h5A;
    logic tdo = 0;
    logic tck, tms, tdi, busy, done, fail;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    jtag_extest_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ir_len(ir_len), .chain_len(chain_len),
        .pat_cnt(pat_cnt), .sample_code(SAMPLE), .extest_code(EXTEST), .stim_vec(stim_v),
        .exp_vec(exp_v), .mask_vec(mask_v), .safe_vec(safe_v), .tdo(tdo), .tck(tck),
        .tms(tms), .tdi(tdi), .busy(busy), .done(done), .fail(fail)
    );

    // target model
    int tst = S_TLR, L = 4, H = 2, fnet = -1, irn = 0, rises = 0, lead = 0;
    bit leadon = 0;
    logic [7:0] tdr = 0, tupd = 0;
    logic [3:0] tir = 4'hF, tirsr = 0, ircap = 4'b0101;
    logic [3:0] irlog [4];

    function automatic int tnx(int s, logic m);
        case (s)
            S_TLR:  return m ? S_TLR : S_RTI;
            S_RTI:  return m ? S_SDR : S_RTI;
            S_SDR:  return m ? S_SIR : S_CDR;
            S_SIR:  return m ? S_TLR : S_CIR;
            S_CDR, S_SHDR, S_E2D: return m ? S_E1D : S_SHDR;
            S_E1D:  return m ? S_UDR : S_PDR;
            S_PDR:  return m ? S_E2D : S_PDR;
            S_CIR, S_SHIR, S_E2I: return m ? S_E1I : S_SHIR;
            S_E1I:  return m ? S_UIR : S_PIR;
            S_PIR:  return m ? S_E2I : S_PIR;
            default: return m ? S_SDR : S_RTI;
        endcase
    endfunction

    function automatic logic [7:0] lmask(int n);
        return 8'((1 << n) - 1);
    endfunction

    function automatic logic [7:0] cap_dr();
        logic [7:0] c = 0;
        if (tir != EXTEST) return 8'hC3 & lmask(L);
        for (int i = 0; i < L; i++)
            if (i < H) c[i] = tupd[i];
            else       c[i] = (fnet == i - H) ? 1'b0 : tupd[i - H];
        return c;
    endfunction

    initial forever begin
        @(posedge tck);
        rises++;
        if (leadon) begin
            if (tms) lead++;
            else leadon = 0;
        end
        case (tst)
            S_CDR:  tdr = cap_dr();
            S_SHDR: tdr = (tdr >> 1) | (8'(tdi) << (L - 1));
            S_UDR:  tupd = tdr;
            S_CIR:  tirsr = ircap;
            S_SHIR: tirsr = (tirsr >> 1) | ({3'b0, tdi} << 3);
            S_UIR:  begin tir = tirsr; if (irn < 4) irlog[irn] = tirsr; irn++; end
            S_TLR:  tir = 4'hF;
            default: ;
        endcase
        tst = tnx(tst, tms);
    end

    initial forever begin
        @(negedge tck);
        if (tst == S_SHDR) tdo = tdr[0];
        else if (tst == S_SHIR) tdo = tirsr[0];
    end

    // pin timing monitor
    int pinerr = 0;
    logic ptck = 0, ptms = 1, ptdi = 0;
    initial forever begin
        @(negedge clk);
        if (tck && !ptck && (tms !== ptms || tdi !== ptdi)) pinerr++;
        ptck = tck; ptms = tms; ptdi = tdi;
    end

    task automatic chk(bit ok, string req, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic bit sbit(int k, int i);
        return ((i + k) % 2) == 0;
    endfunction

    task automatic run(int len, int np, int f, int mode, logic [3:0] icap, bit full);
        int exp_fail = 0, wait_n = 0, exp_rises;
        L = len; H = len / 2; fnet = f; ircap = icap;
        chain_len = 4'(len); pat_cnt = 3'(np);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] s = 8'hFF, e = 8'hFF, m;
            for (int i = 0; i < H; i++) begin
                s[i] = sbit(k, i); e[i] = sbit(k, i); e[H + i] = sbit(k, i);
            end
            m = (mode == 0) ? 8'hFF : (lmask(L) & ~lmask(H));
            if (mode == 2 && f >= 0) m[H + f] = 1'b0;
            stim_v[k] = s; exp_v[k] = e; mask_v[k] = m;
            if (k < np && f >= 0 && mode != 2 && sbit(k, f)) exp_fail = 1;
        end
        if (icap[1:0] != 2'b01) exp_fail = 1;
        tst = S_SHDR; irn = 0; rises = 0; lead = 0; leadon = 1; pinerr = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk(busy == 1'b1, "R11 busy after start", busy, 1);
        while (!done && wait_n < 5000) begin @(negedge clk); wait_n++; end
        exp_rises = 5 + 1 + 2 * (4 + 6) + (np + 1) * (len + 5) + 5;
        chk(done == 1'b1 && busy == 1'b0, "R11 done", done, 1);
        chk(fail == 1'(exp_fail), $sformatf("R6 R8 R9 result L=%0d np=%0d f=%0d m=%0d", len, np, f, mode),
            fail, exp_fail);
        if (full) begin
            chk(rises == exp_rises, "R4 edge count", rises, exp_rises);
            chk(lead >= 5, "R2 leading tms high edges", lead, 5);
            chk(pinerr == 0, "R3 pins moved at rising edge", pinerr, 0);
            chk(irn == 2 && irlog[0] == SAMPLE && irlog[1] == EXTEST, "R5 instruction order",
                irn, 2);
            chk(tupd == (safe_v & lmask(L)), "R10 safe vector", tupd, safe_v & lmask(L));
            chk(tst == S_TLR, "R10 target in reset", tst, S_TLR);
            repeat (7) @(negedge clk);
            chk(done && fail == 1'(exp_fail) && !tck && tms, "R11 R1 hold after run", fail, exp_fail);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && !tck && tms, "R1 reset state", {busy, done, fail, tck, tms}, 1);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(!busy && !tck && tms, "R1 idle", busy, 0);
        // sweep: lengths, pattern counts, stuck nets, mask modes (R6 R7 R8)
        for (int len = 2; len <= 8; len += 2)
            for (int np = 1; np <= 4; np++)
                for (int f = -1; f < len / 2; f++)
                    for (int mode = 0; mode < 3; mode++)
                        run(len, np, f, mode, 4'b0101, (mode == 0));
        // corrupted instruction capture (R9)
        run(4, 2, -1, 1, 4'b0111, 1);
        run(4, 2, -1, 1, 4'b0100, 1);
        run(6, 3, -1, 0, 4'b0101, 1);
        // start while busy ignored (R11)
        fork
            run(4, 1, -1, 0, 4'b0101, 1);
            begin
                repeat (40) @(negedge clk);
                start = 1; @(negedge clk); start = 0;
            end
        join
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule